// File: doc/BRIEF.md
# DMA Channel Request Sequencer

This block decides when one DMA channel moves data and when it holds or returns the system bus. It does not generate addresses or move data. It starts units of transfer, paces them and counts them. A unit can be started in three ways. A falling edge on an active-low request pin starts one unit. A low level on that pin keeps units running back to back. A register write can also start the channel on its own, and it then runs to the end in either cycle-steal or burst fashion.

Toward the bus arbiter the block raises a request and waits for a grant. It then issues a one-cycle strobe for each unit and waits for a one-cycle acknowledge from the bus side. A down-counter holds the number of units left. When the counter reaches zero the block drops its request, pulses a done output and clears its own enable bit. Software can clear the enable bit at any time to stop the channel at the next unit boundary.

Top module: `dma_req_seq`

## Requirements
- R1: After synchronous reset, bus_req, unit_strobe and done are low, chan_enabled is low and remaining is zero.
- R2: When wr_en is sampled high while bus_req is low, it loads the enable bit, the start source (wr_mode: 0 falling edge, 1 low level, 2 auto-request, 3 never starts), the burst bit and the unit count. While bus_req is high, a write changes only the enable bit.
- R3: In source 0, each falling edge of dreq_n that reaches the idle, enabled channel starts exactly one unit. The pin passes through a two-stage synchronizer first.
- R4: In source 0, a falling edge that arrives while bus_req is high is dropped and never starts a later unit.
- R5: In source 1, no request is raised while dreq_n is high. While dreq_n stays low, units follow each other, and bus_req drops for at least one cycle after every unit.
- R6: In source 1, if dreq_n returns high, no further unit is started and remaining keeps its value. A later low level resumes the channel from that count.
- R7: In source 2 with burst at 0, the channel runs the whole count and drops bus_req after every unit.
- R8: In source 2 with burst at 1, bus_req stays high continuously from the first request until the acknowledge of the final unit.
- R9: unit_strobe is high for one cycle per unit, and only while bus_req and bus_gnt are both high. The next strobe waits for unit_ack.
- R10: Each unit_ack decrements remaining. When remaining reaches zero, bus_req falls, done pulses for exactly one cycle and chan_enabled clears.
- R11: Clearing the enable bit stops the channel at the next unit boundary. No further strobe is issued, bus_req returns low, no done pulse is produced and remaining keeps its value.
- R12: A channel whose remaining count is zero never raises bus_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_enable | input | 1 | Enable bit written |
| wr_mode | input | 2 | Start source written (0 edge, 1 level, 2 auto, 3 none) |
| wr_burst | input | 1 | Burst selection for auto-request |
| wr_count | input | 16 | Number of units to transfer |
| dreq_n | input | 1 | Asynchronous active-low request pin |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| unit_ack | input | 1 | One-cycle completion of the current unit |
| bus_req | output | 1 | Bus request toward the arbiter |
| unit_strobe | output | 1 | One-cycle start of a single unit |
| done | output | 1 | One-cycle pulse when the count is exhausted |
| chan_enabled | output | 1 | Current enable bit |
| remaining | output | 16 | Units still to transfer |

## Verification
The assertions assume that bus_gnt is only given while bus_req is high. They also assume that unit_ack arrives exactly once per strobe, and only after the strobe cycle, never in the same cycle. The bench derives the grant from the request through a hold switch, and it returns each acknowledge one cycle after the strobe it answers. The bench changes the configuration only through the write port. It moves the request pin only with spacing longer than the synchronizer, except where R4 deliberately places a second edge inside a unit.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        SRC_EDGE  = 2'd0,
        SRC_LEVEL = 2'd1,
        SRC_AUTO  = 2'd2,
        SRC_NONE  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic en;
        src_e src;
        logic burst;
    } chan_cfg_t;

    function automatic logic keeps_bus(chan_cfg_t c);
        return (c.src == SRC_AUTO) && c.burst;
    endfunction

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic level_on,
    output logic fall_seen
);
    logic [SYNC_STAGES-1:0] shreg;
    logic                   last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '1;
            last_q <= 1'b1;
        end else begin
            shreg  <= {shreg[SYNC_STAGES-2:0], pin_n};
            last_q <= shreg[SYNC_STAGES-1];
        end
    end

    assign level_on  = ~shreg[SYNC_STAGES-1];
    assign fall_seen = last_q & ~shreg[SYNC_STAGES-1];
endmodule

// File: rtl/dma_unit_counter.sv
module dma_unit_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             nonzero,
    output logic             at_one
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - ONE;
    end

    assign nonzero = (cnt != '0);
    assign at_one  = (cnt == ONE);
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
    import dma_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  chan_cfg_t cfg,
    input  logic      cfg_wr,
    input  logic      fall_seen,
    input  logic      level_on,
    input  logic      cnt_nz,
    input  logic      cnt_one,
    input  logic      bus_gnt,
    input  logic      unit_ack,
    output logic      bus_req,
    output logic      unit_strobe,
    output logic      cnt_dec,
    output logic      finish
);
    seq_st_e st_q, st_d;
    logic    want_start;
    logic    level_lost;

    always_comb begin
        unique case (cfg.src)
            SRC_EDGE:  want_start = fall_seen;
            SRC_LEVEL: want_start = level_on;
            SRC_AUTO:  want_start = 1'b1;
            default:   want_start = 1'b0;
        endcase
    end

    assign level_lost = (cfg.src == SRC_LEVEL) && !level_on;

    always_comb begin
        st_d        = st_q;
        unit_strobe = 1'b0;
        cnt_dec     = 1'b0;
        finish      = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (cfg.en && cnt_nz && !cfg_wr && want_start)
                    st_d = ST_REQ;
            end
            ST_REQ: begin
                if (!cfg.en || level_lost) begin
                    st_d = ST_IDLE;
                end else if (bus_gnt) begin
                    unit_strobe = 1'b1;
                    st_d        = ST_XFER;
                end
            end
            ST_XFER: begin
                if (unit_ack) begin
                    cnt_dec = 1'b1;
                    if (cnt_one) begin
                        finish = 1'b1;
                        st_d   = ST_IDLE;
                    end else if (cfg.en && keeps_bus(cfg)) begin
                        st_d = ST_REQ;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign bus_req = (st_q != ST_IDLE);

    AST_BURST_HELD: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_XFER && unit_ack && !cnt_one && cfg.en && keeps_bus(cfg)) |=> bus_req)
        else $error("burst released bus early"); // R8
    AST_STEAL_DROP: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_XFER && unit_ack && !keeps_bus(cfg)) |=> !bus_req)
        else $error("bus not released after unit"); // R7
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        unit_strobe |=> !unit_strobe)
        else $error("strobe longer than one cycle"); // R9
    AST_STROBE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        unit_strobe |-> (cfg.en && bus_gnt))
        else $error("strobe without enable or grant"); // R11
endmodule

// File: rtl/dma_req_seq.sv
module dma_req_seq
    import dma_seq_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_enable,
    input  logic [1:0]       wr_mode,
    input  logic             wr_burst,
    input  logic [CNT_W-1:0] wr_count,
    input  logic             dreq_n,
    input  logic             bus_gnt,
    input  logic             unit_ack,
    output logic             bus_req,
    output logic             unit_strobe,
    output logic             done,
    output logic             chan_enabled,
    output logic [CNT_W-1:0] remaining
);
    chan_cfg_t cfg_q;
    logic      level_on, fall_seen;
    logic      cnt_nz, cnt_one, cnt_dec, finish;
    logic      full_write;

    assign full_write = wr_en && !bus_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{en: 1'b0, src: SRC_NONE, burst: 1'b0};
            done  <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                cfg_q.en <= 1'b0;
            end else if (full_write) begin
                cfg_q <= '{en: wr_enable, src: src_e'(wr_mode), burst: wr_burst};
            end else if (wr_en) begin
                cfg_q.en <= wr_enable;
            end
        end
    end

    assign chan_enabled = cfg_q.en;

    dma_req_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .pin_n(dreq_n),
        .level_on(level_on), .fall_seen(fall_seen)
    );

    dma_unit_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst(rst), .load(full_write), .load_val(wr_count),
        .dec(cnt_dec), .cnt(remaining), .nonzero(cnt_nz), .at_one(cnt_one)
    );

    dma_seq_ctrl ctrl_i (
        .clk(clk), .rst(rst), .cfg(cfg_q), .cfg_wr(wr_en),
        .fall_seen(fall_seen), .level_on(level_on),
        .cnt_nz(cnt_nz), .cnt_one(cnt_one),
        .bus_gnt(bus_gnt), .unit_ack(unit_ack),
        .bus_req(bus_req), .unit_strobe(unit_strobe),
        .cnt_dec(cnt_dec), .finish(finish)
    );

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done)
        else $error("done wider than one cycle"); // R10
    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        done |-> (!bus_req && !chan_enabled))
        else $error("done with request or enable left"); // R10
    AST_IDLE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!bus_req && !wr_en) |=> $stable(remaining))
        else $error("count moved while idle"); // R6
    AST_NO_ZERO_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> (remaining != '0))
        else $error("request with empty count"); // R12
endmodule

// File: tb/dma_req_seq_tb.sv
`timescale 1ns/1ps
module dma_req_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_enable = 1'b0, wr_burst = 1'b0;
    logic [1:0]  wr_mode = 2'd3;
    logic [15:0] wr_count = '0;
    logic        dreq_n = 1'b1;
    logic        bus_gnt, unit_ack = 1'b0, ack_pipe = 1'b0, gnt_hold = 1'b0;
    logic        bus_req, unit_strobe, done, chan_enabled;
    logic [15:0] remaining;

    int n_strobe = 0, n_done = 0, n_fall = 0;
    logic prev_req = 1'b0;
    int total = 0, bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign bus_gnt = bus_req & ~gnt_hold;

    dma_req_seq dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_enable(wr_enable),
        .wr_mode(wr_mode), .wr_burst(wr_burst), .wr_count(wr_count),
        .dreq_n(dreq_n), .bus_gnt(bus_gnt), .unit_ack(unit_ack),
        .bus_req(bus_req), .unit_strobe(unit_strobe), .done(done),
        .chan_enabled(chan_enabled), .remaining(remaining)
    );

    always @(negedge clk) begin
        unit_ack = ack_pipe;
        ack_pipe = unit_strobe;
        if (unit_strobe) n_strobe++;
        if (done) n_done++;
        if (prev_req && !bus_req) n_fall++;
        prev_req = bus_req;
    end

    typedef struct packed {
        logic [1:0] mode;
        logic       burst;
        logic [7:0] cnt;
        logic [3:0] edges;
        logic [7:0] units;
        logic [3:0] dones;
        logic [7:0] falls;
        logic       en;
        logic [7:0] rem;
        logic [3:0] req;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd2, 1'b0, 8'd4, 4'd0, 8'd4, 4'd1, 8'd4, 1'b0, 8'd0, 4'd7},  // R7 steal
        '{2'd2, 1'b1, 8'd5, 4'd0, 8'd5, 4'd1, 8'd1, 1'b0, 8'd0, 4'd8},  // R8 burst
        '{2'd1, 1'b0, 8'd3, 4'd0, 8'd3, 4'd1, 8'd3, 1'b0, 8'd0, 4'd5},  // R5 level
        '{2'd0, 1'b0, 8'd5, 4'd2, 8'd2, 4'd0, 8'd2, 1'b1, 8'd3, 4'd3},  // R3 edges
        '{2'd0, 1'b0, 8'd2, 4'd3, 8'd2, 4'd1, 8'd2, 1'b0, 8'd0, 4'd10}, // R10 end
        '{2'd2, 1'b1, 8'd1, 4'd0, 8'd1, 4'd1, 8'd1, 1'b0, 8'd0, 4'd8},  // R8 single
        '{2'd3, 1'b0, 8'd3, 4'd0, 8'd0, 4'd0, 8'd0, 1'b1, 8'd3, 4'd2},  // R2 none
        '{2'd2, 1'b0, 8'd0, 4'd0, 8'd0, 4'd0, 8'd0, 1'b1, 8'd0, 4'd12}  // R12 zero
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic en, input logic [1:0] mode, input logic b, input int cnt);
        @(negedge clk);
        wr_en = 1'b1; wr_enable = en; wr_mode = mode; wr_burst = b; wr_count = 16'(cnt);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    int s0, d0, f0;
    task automatic mark();
        s0 = n_strobe; d0 = n_done; f0 = n_fall;
    endtask

    initial begin
        idle_cycles(4);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "bus_req", int'(bus_req), 0);
        check("R1", "strobe", int'(unit_strobe), 0);
        check("R1", "done", int'(done), 0);
        check("R1", "enable", int'(chan_enabled), 0);
        check("R1", "remaining", int'(remaining), 0);

        foreach (VECS[i]) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            mark();
            cfg_write(1'b1, VECS[i].mode, VECS[i].burst, int'(VECS[i].cnt));
            if (VECS[i].mode == 2'd0) begin
                for (int e = 0; e < int'(VECS[i].edges); e++) begin
                    dreq_n = 1'b0; idle_cycles(3);
                    dreq_n = 1'b1; idle_cycles(20);
                end
            end else if (VECS[i].mode == 2'd1) begin
                dreq_n = 1'b0;
            end
            idle_cycles(150);
            dreq_n = 1'b1;
            idle_cycles(10);
            check(tag, "units", n_strobe - s0, int'(VECS[i].units));
            check(tag, "done pulses", n_done - d0, int'(VECS[i].dones));
            check(tag, "bus releases", n_fall - f0, int'(VECS[i].falls));
            check(tag, "enable", int'(chan_enabled), int'(VECS[i].en));
            check(tag, "remaining", int'(remaining), int'(VECS[i].rem));
            cfg_write(1'b0, 2'd3, 1'b0, 0);
            idle_cycles(5);
        end

        // R4: second edge while a unit is pending is dropped
        mark();
        gnt_hold = 1'b1;
        cfg_write(1'b1, 2'd0, 1'b0, 5);
        dreq_n = 1'b0; idle_cycles(3); dreq_n = 1'b1; idle_cycles(10);
        check("R4", "pending request", int'(bus_req), 1);
        dreq_n = 1'b0; idle_cycles(3); dreq_n = 1'b1; idle_cycles(10);
        check("R9", "no strobe without grant", n_strobe - s0, 0);
        gnt_hold = 1'b0;
        idle_cycles(40);
        check("R4", "units", n_strobe - s0, 1);
        check("R4", "remaining", int'(remaining), 4);
        cfg_write(1'b0, 2'd3, 1'b0, 0);

        // R6: level pause keeps count, resume finishes
        mark();
        cfg_write(1'b1, 2'd1, 1'b0, 6);
        dreq_n = 1'b0;
        while (n_strobe - s0 < 2) @(posedge clk);
        @(negedge clk);
        gnt_hold = 1'b1; dreq_n = 1'b1;
        idle_cycles(10);
        gnt_hold = 1'b0;
        idle_cycles(30);
        check("R6", "units at pause", n_strobe - s0, 2);
        check("R6", "remaining kept", int'(remaining), 4);
        check("R6", "bus_req idle", int'(bus_req), 0);
        check("R6", "still enabled", int'(chan_enabled), 1);
        dreq_n = 1'b0;
        idle_cycles(100);
        dreq_n = 1'b1;
        check("R6", "units after resume", n_strobe - s0, 6);
        check("R10", "done after resume", n_done - d0, 1);
        idle_cycles(5);

        // R11: abort in cycle-steal mode
        mark();
        cfg_write(1'b1, 2'd2, 1'b0, 10);
        while (n_strobe - s0 < 3) @(posedge clk);
        cfg_write(1'b0, 2'd2, 1'b0, 10);
        idle_cycles(30);
        check("R11", "steal units", n_strobe - s0, 3);
        check("R11", "steal remaining", int'(remaining), 7);
        check("R11", "steal done", n_done - d0, 0);
        check("R11", "steal bus_req", int'(bus_req), 0);

        // R11: abort in burst mode
        mark();
        cfg_write(1'b1, 2'd2, 1'b1, 10);
        while (n_strobe - s0 < 3) @(posedge clk);
        cfg_write(1'b0, 2'd2, 1'b1, 10);
        idle_cycles(30);
        check("R11", "burst units", n_strobe - s0, 3);
        check("R11", "burst remaining", int'(remaining), 7);
        check("R11", "burst bus_req", int'(bus_req), 0);

        // R2: write while busy changes only the enable bit
        mark();
        gnt_hold = 1'b1;
        cfg_write(1'b1, 2'd2, 1'b0, 4);
        idle_cycles(5);
        cfg_write(1'b1, 2'd0, 1'b1, 99);
        idle_cycles(5);
        check("R2", "count not reloaded", int'(remaining), 4);
        gnt_hold = 1'b0;
        idle_cycles(60);
        check("R2", "units", n_strobe - s0, 4);
        check("R2", "kept steal releases", n_fall - f0, 4);
        check("R2", "done", n_done - d0, 1);
        check("R2", "remaining", int'(remaining), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule